// File: doc/BRIEF.md
# System Management Entry and Resume Controller

This block handles the bookkeeping a processor core needs around a system-management interrupt. It accepts an interrupt request at an instruction boundary, holds off the state save until outstanding stores have drained, and then masks ordinary interrupts, NMI, single-step and debug traps. It also sets up the handler-visible slots: the relocatable base, the restart word and the I/O trap word. It reports the save-area base and the handler entry vector.

While the handler runs it may read and write those slots through a small offset-addressed port. When the core presents a resume request, the block checks the relocated base for 32-Kbyte alignment. It then either commits the base and signals a normal return, with a restart of the trapped I/O instruction or of the interrupted HALT where requested, or it signals shutdown and leaves the base untouched. The instruction core and memory are outside the block. Only the slots the block itself owns are modelled.

Top module: `smm_ctrl`

## Requirements
- R1: After reset the base is 0003_0000h, the entry vector is 0003_8000h (base plus 8000h), events are not masked, and no resume pulse is active.
- R2: A request accepted while stores_pending_i is high does not start the state save. save_start_o rises in the cycle after the first clock edge that samples stores_pending_i low, and never while stores are pending.
- R3: events_masked_o goes high in the cycle after a request is accepted. It stays high through the save, the handler and the resume evaluation.
- R4: At entry the I/O trap word (offset FF04h) is loaded as {io address in bits 31:16, zeros in 15:2, valid flag in bit 1, read/write flag in bit 0}. The restart word (offset FF00h) is loaded with bits 15:0 = 0000h and bit 16 = the HALT state at request time.
- R5: Offset FEFCh reads 0003_0000h (relocation flag bit 17, trap-extension flag bit 16, revision 0). Writes to FEFCh or FF04h do not change what they read back.
- R6: Offset FEF8h reads the current base at entry. An aligned value written there takes effect at resume for save_base_o and for the entry vector of every later request.
- R7: At resume a base value with any of bits 14:0 set gives a one-cycle shutdown_o pulse. It gives no resume_done_o and no restart pulse, and the previous base is kept.
- R8: On a normal resume, restart_io_o pulses with resume_done_o when restart word bits 15:0 equal 00FFh and the trap word valid flag (bit 1) is set.
- R9: On a normal resume, restart_halt_o pulses with resume_done_o when restart word bit 16 is still set and no I/O restart is issued. The handler cancels it by clearing the bit.
- R10: A request accepted in the cycle where resume_done_o is high loads a zero trap word. No I/O restart is issued for that entry, even with 00FFh in the restart word.
- R11: shutdown_o, resume_done_o, restart_io_o and restart_halt_o last one cycle. Slot writes outside the handler phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smi_req_i | input | 1 | Interrupt request at an instruction boundary |
| rsm_req_i | input | 1 | Resume request from the handler |
| stores_pending_i | input | 1 | Outstanding stores not yet complete |
| in_halt_i | input | 1 | Core is in HALT when the request is taken |
| io_trap_valid_i | input | 1 | Request trapped a valid I/O instruction |
| io_trap_rw_i | input | 1 | Direction of the trapped I/O access |
| io_trap_addr_i | input | 16 | Port address of the trapped I/O access |
| slot_we_i | input | 1 | Slot write strobe (handler phase only) |
| slot_ofs_i | input | 16 | Slot offset in the save area |
| slot_wdata_i | input | 32 | Slot write data |
| slot_rdata_o | output | 32 | Slot read data at slot_ofs_i |
| in_handler_o | output | 1 | Handler phase, slot access open |
| save_start_o | output | 1 | State save begins this cycle |
| events_masked_o | output | 1 | INTR, NMI, single-step and debug traps masked |
| save_base_o | output | 32 | Current save-area base |
| entry_vector_o | output | 32 | Handler entry address |
| restart_io_o | output | 1 | Re-execute the trapped I/O instruction |
| restart_halt_o | output | 1 | Return into HALT |
| shutdown_o | output | 1 | Illegal relocated base at resume |
| resume_done_o | output | 1 | Normal return completed |

## Verification
Clocked properties check on every cycle that the save never starts while stores are pending and that accepting a request masks events on the next cycle. They also check that shutdown excludes all other resume pulses, that an I/O restart excludes a HALT restart, that the pulses last one cycle, that a misaligned base leaves the base register unchanged, and that a chained entry clears the trap word. The vector-driven scenarios show the behaviour that depends on what the handler writes: the slot contents at entry, base relocation carried into later entries, the chosen restart, the read-only slots and the back-to-back case.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DRAIN, ST_SAVE, ST_HANDLER, ST_EVAL
  } smm_state_e;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFS_W    = 16;
  localparam int unsigned HALT_BIT = 16;

  localparam logic [OFS_W-1:0]  OFS_BASE    = 16'hFEF8;
  localparam logic [OFS_W-1:0]  OFS_REV     = 16'hFEFC;
  localparam logic [OFS_W-1:0]  OFS_RESTART = 16'hFF00;
  localparam logic [OFS_W-1:0]  OFS_TRAP    = 16'hFF04;

  localparam logic [DATA_W-1:0] REV_ID       = 32'h0003_0000;
  localparam logic [15:0]       RESTART_CODE = 16'h00FF;
endpackage

// File: rtl/smm_base_reg.sv
module smm_base_reg #(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        ALIGN_W    = 15,
  parameter logic [ADDR_W-1:0]  BASE_RESET = 32'h0003_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] cand_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              cand_bad_o
);
  logic [ADDR_W-1:0] base_q;

  assign cand_bad_o = |cand_i[ALIGN_W-1:0];
  assign base_o     = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      base_q <= BASE_RESET;
    else if (commit_i && !cand_bad_o) base_q <= cand_i;
  end

  p_bad_base_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cand_bad_o) |=> $stable(base_q));
endmodule

// File: rtl/smm_slot_file.sv
module smm_slot_file
  import smm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IOA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] cur_base_i,
  input  logic              halt_i,
  input  logic              trap_valid_i,
  input  logic              trap_rw_i,
  input  logic [IOA_W-1:0]  trap_addr_i,
  input  logic              suppress_trap_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] new_base_o,
  output logic              io_restart_o,
  output logic              halt_restart_o
);
  localparam int unsigned PAD_W = DATA_W - IOA_W - 2;

  logic [ADDR_W-1:0] new_base_q;
  logic [DATA_W-1:0] restart_q;
  logic [DATA_W-1:0] trap_q;
  logic [DATA_W-1:0] trap_init;
  logic [DATA_W-1:0] restart_init;

  always_comb begin
    trap_init    = suppress_trap_i ? '0
                 : {trap_addr_i, {PAD_W{1'b0}}, trap_valid_i, trap_rw_i};
    restart_init = '0;
    restart_init[HALT_BIT] = halt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_base_q <= '0;
      restart_q  <= '0;
      trap_q     <= '0;
    end else if (init_i) begin
      new_base_q <= cur_base_i;
      restart_q  <= restart_init;
      trap_q     <= trap_init;
    end else if (we_i) begin
      // read-only slots simply have no write case
      case (ofs_i)
        OFS_BASE:    new_base_q <= wdata_i[ADDR_W-1:0];
        OFS_RESTART: restart_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (ofs_i)
      OFS_BASE:    rdata_o = DATA_W'(new_base_q);
      OFS_REV:     rdata_o = REV_ID;
      OFS_RESTART: rdata_o = restart_q;
      OFS_TRAP:    rdata_o = trap_q;
      default:     rdata_o = '0;
    endcase
  end

  assign new_base_o     = new_base_q;
  assign io_restart_o   = (restart_q[15:0] == RESTART_CODE) && trap_q[1];
  assign halt_restart_o = restart_q[HALT_BIT];

  p_chained_trap_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && suppress_trap_i) |=> (trap_q == '0));
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       ALIGN_W    = 15,
  parameter int unsigned       IOA_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_RESET = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] VEC_OFS    = 32'h0000_8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smi_req_i,
  input  logic              rsm_req_i,
  input  logic              stores_pending_i,
  input  logic              in_halt_i,
  input  logic              io_trap_valid_i,
  input  logic              io_trap_rw_i,
  input  logic [IOA_W-1:0]  io_trap_addr_i,
  input  logic              slot_we_i,
  input  logic [OFS_W-1:0]  slot_ofs_i,
  input  logic [DATA_W-1:0] slot_wdata_i,
  output logic [DATA_W-1:0] slot_rdata_o,
  output logic              in_handler_o,
  output logic              save_start_o,
  output logic              events_masked_o,
  output logic [ADDR_W-1:0] save_base_o,
  output logic [ADDR_W-1:0] entry_vector_o,
  output logic              restart_io_o,
  output logic              restart_halt_o,
  output logic              shutdown_o,
  output logic              resume_done_o
);
  smm_state_e state_q, state_d;

  logic             cap_halt_q, cap_valid_q, cap_rw_q, chained_q;
  logic [IOA_W-1:0] cap_addr_q;
  logic             sd_q, done_q, rio_q, rh_q;

  logic              accept, evaluating;
  logic [ADDR_W-1:0] base, new_base;
  logic              base_bad, io_req, halt_req;

  assign accept     = (state_q == ST_IDLE) && smi_req_i;
  assign evaluating = (state_q == ST_EVAL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (smi_req_i)         state_d = ST_DRAIN;
      ST_DRAIN:   if (!stores_pending_i) state_d = ST_SAVE;
      ST_SAVE:                           state_d = ST_HANDLER;
      ST_HANDLER: if (rsm_req_i)         state_d = ST_EVAL;
      ST_EVAL:                           state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cap_halt_q  <= 1'b0;
      cap_valid_q <= 1'b0;
      cap_rw_q    <= 1'b0;
      cap_addr_q  <= '0;
      chained_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cap_halt_q  <= in_halt_i;
        cap_valid_q <= io_trap_valid_i;
        cap_rw_q    <= io_trap_rw_i;
        cap_addr_q  <= io_trap_addr_i;
        chained_q   <= done_q;  // taken right on top of a resume
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q   <= 1'b0;
      done_q <= 1'b0;
      rio_q  <= 1'b0;
      rh_q   <= 1'b0;
    end else begin
      sd_q   <= evaluating &&  base_bad;
      done_q <= evaluating && !base_bad;
      rio_q  <= evaluating && !base_bad && io_req;
      rh_q   <= evaluating && !base_bad && !io_req && halt_req;
    end
  end

  smm_base_reg #(
    .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .BASE_RESET(BASE_RESET)
  ) u_base (
    .clk_i, .rst_ni,
    .commit_i  (evaluating),
    .cand_i    (new_base),
    .base_o    (base),
    .cand_bad_o(base_bad)
  );

  smm_slot_file #(.ADDR_W(ADDR_W), .IOA_W(IOA_W)) u_slots (
    .clk_i, .rst_ni,
    .init_i         (state_q == ST_SAVE),
    .cur_base_i     (base),
    .halt_i         (cap_halt_q),
    .trap_valid_i   (cap_valid_q),
    .trap_rw_i      (cap_rw_q),
    .trap_addr_i    (cap_addr_q),
    .suppress_trap_i(chained_q),
    .we_i           (slot_we_i && in_handler_o),
    .ofs_i          (slot_ofs_i),
    .wdata_i        (slot_wdata_i),
    .rdata_o        (slot_rdata_o),
    .new_base_o     (new_base),
    .io_restart_o   (io_req),
    .halt_restart_o (halt_req)
  );

  assign in_handler_o    = (state_q == ST_HANDLER);
  assign save_start_o    = (state_q == ST_SAVE);
  assign events_masked_o = (state_q != ST_IDLE);
  assign save_base_o     = base;
  assign entry_vector_o  = base + VEC_OFS;
  assign restart_io_o    = rio_q;
  assign restart_halt_o  = rh_q;
  assign shutdown_o      = sd_q;
  assign resume_done_o   = done_q;

  p_save_after_drain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_start_o |-> $past(!stores_pending_i));
  p_mask_on_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_req_i && !events_masked_o) |=> events_masked_o);
  p_shutdown_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !(resume_done_o || restart_io_o || restart_halt_o));
  p_io_over_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_io_o |-> (resume_done_o && !restart_halt_o));
  p_halt_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_halt_o |-> resume_done_o);
  p_single_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_done_o || shutdown_o) |=> !(resume_done_o || shutdown_o));
endmodule

// File: tb/smm_ctrl_test.sv
module smm_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smi_req = 0, rsm_req = 0, stores_pending = 0, in_halt = 0;
  logic        tvalid = 0, trw = 0, slot_we = 0;
  logic [15:0] taddr = '0, slot_ofs = '0;
  logic [31:0] slot_wdata = '0, slot_rdata, save_base, entry_vector;
  logic        in_handler, save_start, masked, rio, rh, sd, done;

  int checks = 0;
  int fails  = 0;
  logic [31:0] cur_base;

  always #2 clk = ~clk;

  smm_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .smi_req_i(smi_req), .rsm_req_i(rsm_req),
    .stores_pending_i(stores_pending), .in_halt_i(in_halt),
    .io_trap_valid_i(tvalid), .io_trap_rw_i(trw), .io_trap_addr_i(taddr),
    .slot_we_i(slot_we), .slot_ofs_i(slot_ofs), .slot_wdata_i(slot_wdata),
    .slot_rdata_o(slot_rdata), .in_handler_o(in_handler),
    .save_start_o(save_start), .events_masked_o(masked),
    .save_base_o(save_base), .entry_vector_o(entry_vector),
    .restart_io_o(rio), .restart_halt_o(rh), .shutdown_o(sd),
    .resume_done_o(done)
  );

  typedef struct packed {
    logic        wr_base;
    logic [31:0] nbase;
    logic        halt;
    logic        tv;
    logic        wr_rst;
    logic [31:0] rst_val;
    logic        e_sd;
    logic        e_rio;
    logic        e_rh;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 32'h0,          1'b0, 1'b1, 1'b1, 32'h0000_00FF, 1'b0, 1'b1, 1'b0},
    '{1'b0, 32'h0,          1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,          1'b1, 1'b1, 1'b1, 32'h0001_00FF, 1'b0, 1'b1, 1'b0},
    '{1'b1, 32'h0004_8000,  1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h0005_0010,  1'b1, 1'b1, 1'b1, 32'h0001_00FF, 1'b1, 1'b0, 1'b0},
    '{1'b0, 32'h0,          1'b0, 1'b0, 1'b1, 32'h0000_00FF, 1'b0, 1'b0, 1'b0},
    '{1'b0, 32'h0,          1'b1, 1'b0, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd_slot(input logic [15:0] ofs, output logic [31:0] val);
    slot_ofs = ofs;
    #1 val = slot_rdata;
  endtask

  task automatic wr_slot(input logic [15:0] ofs, input logic [31:0] val);
    @(negedge clk);
    slot_ofs = ofs; slot_wdata = val; slot_we = 1'b1;
    @(negedge clk);
    slot_we = 1'b0;
  endtask

  // request SMI, hold stores pending for pend cycles, end at first handler cycle
  task automatic enter(input logic h, input logic v, input logic rw,
                       input logic [15:0] a, input int pend);
    @(negedge clk);
    smi_req = 1'b1; in_halt = h; tvalid = v; trw = rw; taddr = a;
    stores_pending = (pend > 0);
    @(negedge clk);
    smi_req = 1'b0; in_halt = 1'b0; tvalid = 1'b0; trw = 1'b0; taddr = '0;
    for (int k = 0; k < pend; k++) begin
      chk("R2 save held while stores pending", {31'b0, save_start}, 32'd0);
      chk("R3 masked while draining", {31'b0, masked}, 32'd1);
      @(negedge clk);
    end
    stores_pending = 1'b0;
    @(negedge clk);
    chk("R2 save starts after drain", {31'b0, save_start}, 32'd1);
    @(negedge clk);
    chk("R3 masked in handler", {31'b0, masked & in_handler}, 32'd1);
  endtask

  // after return the pulses of the evaluation are visible
  task automatic resume;
    rsm_req = 1'b1;
    @(negedge clk);
    rsm_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 base", save_base, 32'h0003_0000);
    chk("R1 vector", entry_vector, 32'h0003_8000);
    chk("R1 unmasked", {31'b0, masked}, 32'd0);
    chk("R1 no pulses", {28'b0, rio, rh, sd, done}, 32'd0);
    cur_base = 32'h0003_0000;

    // vector table: one full entry/handler/resume per row
    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      enter(v.halt, v.tv, i[0], 16'h0300 + 16'(i), i % 3);
      chk("R6 vector at entry", entry_vector, cur_base + 32'h8000);
      rd_slot(16'hFEF8, r); chk("R6 base slot", r, cur_base);
      rd_slot(16'hFF04, r); chk("R4 trap word", r, {16'h0300 + 16'(i), 14'b0, v.tv, i[0]});
      rd_slot(16'hFF00, r); chk("R4 restart word", r, {15'b0, v.halt, 16'h0});
      if (v.wr_base) wr_slot(16'hFEF8, v.nbase);
      if (v.wr_rst)  wr_slot(16'hFF00, v.rst_val);
      @(negedge clk);
      resume;
      chk("R7 shutdown", {31'b0, sd}, {31'b0, v.e_sd});
      chk("R7 done unless shutdown", {31'b0, done}, {31'b0, !v.e_sd});
      chk("R8 restart io", {31'b0, rio}, {31'b0, v.e_rio});
      chk("R9 restart halt", {31'b0, rh}, {31'b0, v.e_rh});
      if (v.wr_base && (v.nbase[14:0] == 15'd0)) cur_base = v.nbase;
      chk("R6 R7 base after resume", save_base, cur_base);
      @(negedge clk);
      chk("R11 pulses one cycle", {28'b0, rio, rh, sd, done}, 32'd0);
      chk("R3 unmasked after resume", {31'b0, masked}, 32'd0);
    end

    // R5 read-only slots, R6 relocation carried into later entry
    enter(1'b0, 1'b1, 1'b1, 16'hABCD, 0);
    chk("R6 relocated vector", entry_vector, 32'h0005_0000);
    rd_slot(16'hFEFC, r); chk("R5 revision", r, 32'h0003_0000);
    wr_slot(16'hFEFC, 32'hFFFF_FFFF);
    wr_slot(16'hFF04, 32'h0);
    rd_slot(16'hFEFC, r); chk("R5 revision after write", r, 32'h0003_0000);
    rd_slot(16'hFF04, r); chk("R5 trap word after write", r, 32'hABCD_0003);
    wr_slot(16'hFF00, 32'h0000_00FF);
    @(negedge clk);
    resume;
    chk("R8 restart io", {31'b0, rio & done}, 32'd1);
    // R10 request taken in the resume_done cycle
    smi_req = 1'b1; tvalid = 1'b1; taddr = 16'h1234; trw = 1'b1;
    @(negedge clk);
    smi_req = 1'b0; tvalid = 1'b0; taddr = '0; trw = 1'b0;
    @(negedge clk);
    chk("R10 chained save start", {31'b0, save_start}, 32'd1);
    @(negedge clk);
    rd_slot(16'hFF04, r); chk("R10 chained trap word cleared", r, 32'h0);
    wr_slot(16'hFF00, 32'h0000_00FF);
    @(negedge clk);
    resume;
    chk("R10 no io restart", {31'b0, rio}, 32'd0);
    chk("R10 done", {31'b0, done}, 32'd1);

    // R11 slot write outside handler ignored
    wr_slot(16'hFEF8, 32'h0010_0000);
    chk("R11 base unchanged in idle", save_base, 32'h0004_8000);
    enter(1'b0, 1'b0, 1'b0, 16'h0, 0);
    rd_slot(16'hFEF8, r); chk("R11 idle write had no effect", r, 32'h0004_8000);
    @(negedge clk);
    resume;
    chk("R11 base after resume", save_base, 32'h0004_8000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule